// File: doc/BRIEF.md
# Pointer Addressing-Mode Generator

This block computes the byte address for a load or store and the new value of the pointer register that supplies it. Each request gives a base pointer, a displacement, an access size and a mode. The displacement is either a 5-bit unsigned constant, the contents of a register, or absent. It is a count of elements, and the block scales it to bytes by the access size. The mode chooses two things: whether the access uses the original pointer or the modified one, and whether the modified pointer is written back to the register file.

The block has one register stage. A request presented with `req_valid` high is captured on a rising clock edge. Its address, new pointer value and write-back strobe appear on the outputs until the next accepted request. The register file and the memory port sit outside the block. They take `eff_addr` as the access address and write `ptr_new` back to the pointer register when `ptr_wb` is high.

Top module: `ptr_addr_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `acc_valid`, `ptr_wb`, `eff_addr` and `ptr_new` are all zero.
- R2: Outputs change one clock edge after a request is sampled. `acc_valid` equals the value `req_valid` had at the previous edge.
- R3: The displacement in bytes is the element count shifted left by `acc_size`. The encoding is 0 = byte (×1), 1 = halfword (×2), 2 = word (×4), 3 = doubleword (×8).
- R4: `disp_src` selects the element count. The encoding is 1 = `disp_const` (5-bit, zero-extended), 2 = `disp_reg`, and 0 or 3 = no displacement.
- R5: Mode 0 (plain) gives `eff_addr` = base and `ptr_new` = base, with `ptr_wb` low.
- R6: Mode 1 (offset add) and mode 2 (offset subtract) give `eff_addr` = base ± scaled displacement and `ptr_new` = base, with `ptr_wb` low.
- R7: Mode 3 (pre-increment) and mode 4 (pre-decrement) give `eff_addr` = `ptr_new` = base ± scaled displacement, with `ptr_wb` high.
- R8: Mode 5 (post-increment) and mode 6 (post-decrement) give `eff_addr` = base and `ptr_new` = base ± scaled displacement, with `ptr_wb` high.
- R9: With no displacement, the increment and decrement modes (3 to 6) step by one element. The offset modes (1, 2) use zero.
- R10: All address arithmetic, including the scaling shift, wraps modulo 2^32.
- R11: Mode 7 is unused and behaves exactly as mode 0.
- R12: `ptr_wb` is high only with `acc_valid`. A cycle with `req_valid` low leaves `eff_addr` and `ptr_new` unchanged and drives `acc_valid` and `ptr_wb` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code (0..7) |
| acc_size | input | 2 | Access size code |
| disp_src | input | 2 | Displacement source select |
| disp_const | input | 5 | Unsigned constant displacement, in elements |
| disp_reg | input | 32 | Register displacement, in elements |
| base_ptr | input | 32 | Pointer register value |
| acc_valid | output | 1 | Registered outputs belong to an accepted request |
| eff_addr | output | 32 | Byte address of the access |
| ptr_new | output | 32 | Pointer value after the access |
| ptr_wb | output | 1 | Write `ptr_new` back to the pointer register |

## Verification
Each of the eight mode codes is tried at least once. The four sizes are spread across the modes, so a wrong scale factor shows up as a wrong byte distance. Pairing increment and decrement forms of the same base separates add from subtract. Pairing pre and post forms shows whether the access address comes from the modified or the original pointer. Patterns with an absent displacement, with the largest 5-bit constant, and with register counts large enough to overflow the pointer or the scaling shift check the default step, zero-extension and wrap-around. Idle cycles between requests show that the outputs hold and that the write-back strobe is not repeated.

// File: rtl/agu_pkg.sv
package agu_pkg;

    parameter int ADDR_W  = 32;
    parameter int CONST_W = 5;

    typedef enum logic [2:0] {
        MD_PLAIN    = 3'd0,
        MD_OFS_ADD  = 3'd1,
        MD_OFS_SUB  = 3'd2,
        MD_PRE_INC  = 3'd3,
        MD_PRE_DEC  = 3'd4,
        MD_POST_INC = 3'd5,
        MD_POST_DEC = 3'd6,
        MD_SPARE    = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        DS_NONE  = 2'd0,
        DS_CONST = 2'd1,
        DS_REG   = 2'd2,
        DS_RSVD  = 2'd3
    } dsrc_e;

    typedef struct packed {
        logic subtract;   // step downward
        logic pre_addr;   // access uses modified pointer
        logic modify;     // write modified pointer back
        logic step_dflt;  // absent displacement means one element
    } mode_ctl_t;

endpackage

// File: rtl/agu_mode_decode.sv
module agu_mode_decode
    import agu_pkg::*;
(
    input  logic [2:0] mode_code,
    output mode_ctl_t  ctl
);
    always_comb begin
        ctl = '0;
        unique case (mode_e'(mode_code))
            MD_OFS_ADD: begin
                ctl.pre_addr = 1'b1;
            end
            MD_OFS_SUB: begin
                ctl.pre_addr = 1'b1;
                ctl.subtract = 1'b1;
            end
            MD_PRE_INC: begin
                ctl.pre_addr  = 1'b1;
                ctl.modify    = 1'b1;
                ctl.step_dflt = 1'b1;
            end
            MD_PRE_DEC: begin
                ctl.pre_addr  = 1'b1;
                ctl.modify    = 1'b1;
                ctl.subtract  = 1'b1;
                ctl.step_dflt = 1'b1;
            end
            MD_POST_INC: begin
                ctl.modify    = 1'b1;
                ctl.step_dflt = 1'b1;
            end
            MD_POST_DEC: begin
                ctl.modify    = 1'b1;
                ctl.subtract  = 1'b1;
                ctl.step_dflt = 1'b1;
            end
            MD_PLAIN, MD_SPARE: begin
                ctl = '0;
            end
        endcase
    end
endmodule

// File: rtl/agu_disp_scale.sv
module agu_disp_scale
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CONST_W
) (
    input  logic [1:0]    src,
    input  logic [1:0]    size,
    input  logic [CW-1:0] cval,
    input  logic [AW-1:0] rval,
    input  logic          step_dflt,
    output logic [AW-1:0] bytes
);
    localparam int SHW = 2;

    logic [AW-1:0]  elems;
    logic [SHW-1:0] shamt;

    always_comb begin
        unique case (dsrc_e'(src))
            DS_CONST:         elems = {{(AW-CW){1'b0}}, cval};
            DS_REG:           elems = rval;
            DS_NONE, DS_RSVD: elems = step_dflt ? AW'(1) : '0;
        endcase
    end

    assign shamt = size;
    assign bytes = elems << shamt;   // upper bits drop: modulo 2^AW
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] delta,
    input  logic          subtract,
    output logic [AW-1:0] result
);
    assign result = subtract ? (base - delta) : (base + delta);
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CONST_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    mode,
    input  logic [1:0]    acc_size,
    input  logic [1:0]    disp_src,
    input  logic [CW-1:0] disp_const,
    input  logic [AW-1:0] disp_reg,
    input  logic [AW-1:0] base_ptr,
    output logic          acc_valid,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] ptr_new,
    output logic          ptr_wb
);
    mode_ctl_t     ctl;
    logic [AW-1:0] scaled;
    logic [AW-1:0] moved;
    logic [AW-1:0] nxt_addr;
    logic [AW-1:0] nxt_ptr;
    logic          nxt_wb;

    agu_mode_decode u_dec (
        .mode_code (mode),
        .ctl       (ctl)
    );

    agu_disp_scale #(.AW(AW), .CW(CW)) u_scale (
        .src       (disp_src),
        .size      (acc_size),
        .cval      (disp_const),
        .rval      (disp_reg),
        .step_dflt (ctl.step_dflt),
        .bytes     (scaled)
    );

    agu_addsub #(.AW(AW)) u_arith (
        .base     (base_ptr),
        .delta    (scaled),
        .subtract (ctl.subtract),
        .result   (moved)
    );

    always_comb begin
        nxt_addr = ctl.pre_addr ? moved : base_ptr;
        nxt_ptr  = ctl.modify   ? moved : base_ptr;
        nxt_wb   = ctl.modify;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid <= 1'b0;
            ptr_wb    <= 1'b0;
            eff_addr  <= '0;
            ptr_new   <= '0;
        end else begin
            acc_valid <= req_valid;
            ptr_wb    <= req_valid & nxt_wb;
            if (req_valid) begin
                eff_addr <= nxt_addr;
                ptr_new  <= nxt_ptr;
            end
        end
    end
endmodule

// File: rtl/ptr_addr_gen_chk.sv
module ptr_addr_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [2:0]    mode,
    input logic [AW-1:0] base_ptr,
    input logic          acc_valid,
    input logic [AW-1:0] eff_addr,
    input logic [AW-1:0] ptr_new,
    input logic          ptr_wb
);
    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> acc_valid);
    // R12
    a_r12_wb_needs_valid: assert property (@(posedge clk) disable iff (rst)
        ptr_wb |-> acc_valid);
    // R12
    a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!acc_valid && !ptr_wb && $stable(eff_addr) && $stable(ptr_new)));
    // R8
    a_r8_post_orig_addr: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (mode == 3'd5 || mode == 3'd6))
        |=> (ptr_wb && eff_addr == $past(base_ptr)));
    // R7
    a_r7_pre_same: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (mode == 3'd3 || mode == 3'd4))
        |=> (ptr_wb && eff_addr == ptr_new));
    // R5, R6, R11
    a_r6_no_modify: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (mode == 3'd0 || mode == 3'd1 || mode == 3'd2 || mode == 3'd7))
        |=> (!ptr_wb && ptr_new == $past(base_ptr)));
    // R5, R11
    a_r5_plain_addr: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (mode == 3'd0 || mode == 3'd7))
        |=> (eff_addr == $past(base_ptr)));
endmodule

bind ptr_addr_gen ptr_addr_gen_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .mode      (mode),
    .base_ptr  (base_ptr),
    .acc_valid (acc_valid),
    .eff_addr  (eff_addr),
    .ptr_new   (ptr_new),
    .ptr_wb    (ptr_wb)
);

// File: tb/test_ptr_addr_gen.sv
module test_ptr_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  mode;
    logic [1:0]  acc_size;
    logic [1:0]  disp_src;
    logic [4:0]  disp_const;
    logic [31:0] disp_reg;
    logic [31:0] base_ptr;
    logic        acc_valid;
    logic [31:0] eff_addr;
    logic [31:0] ptr_new;
    logic        ptr_wb;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    ptr_addr_gen i_ptr_addr_gen (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
        .acc_size(acc_size), .disp_src(disp_src), .disp_const(disp_const),
        .disp_reg(disp_reg), .base_ptr(base_ptr), .acc_valid(acc_valid),
        .eff_addr(eff_addr), .ptr_new(ptr_new), .ptr_wb(ptr_wb)
    );

    // {mode 3, size 2, src 2, const 5, base 32, reg 32, exp_addr 32, exp_new 32, exp_wb 1, req 4}
    localparam int NV = 14;
    localparam logic [144:0] VEC [NV] = '{
        {3'd0,2'd2,2'd1,5'd5, 32'h0000_1000,32'h0,          32'h0000_1000,32'h0000_1000,1'b0,4'd5},  // R5
        {3'd1,2'd2,2'd1,5'd3, 32'h0000_1000,32'h0,          32'h0000_100C,32'h0000_1000,1'b0,4'd6},  // R6 R3 word
        {3'd2,2'd1,2'd2,5'd0, 32'h0000_2000,32'h5,          32'h0000_1FF6,32'h0000_2000,1'b0,4'd6},  // R6 R4 reg
        {3'd3,2'd3,2'd1,5'd2, 32'h0000_0100,32'h0,          32'h0000_0110,32'h0000_0110,1'b1,4'd7},  // R7 R3 dword
        {3'd4,2'd0,2'd1,5'd31,32'h0000_0100,32'h0,          32'h0000_00E1,32'h0000_00E1,1'b1,4'd7},  // R7 R4 max const
        {3'd5,2'd2,2'd0,5'd0, 32'h0000_0400,32'h0,          32'h0000_0400,32'h0000_0404,1'b1,4'd8},  // R8 R9
        {3'd6,2'd1,2'd0,5'd0, 32'h0000_0400,32'h0,          32'h0000_0400,32'h0000_03FE,1'b1,4'd8},  // R8 R9
        {3'd1,2'd3,2'd0,5'd9, 32'h0000_0500,32'h0,          32'h0000_0500,32'h0000_0500,1'b0,4'd9},  // R9 offset none
        {3'd3,2'd2,2'd1,5'd1, 32'hFFFF_FFFE,32'h0,          32'h0000_0002,32'h0000_0002,1'b1,4'd10}, // R10
        {3'd6,2'd0,2'd1,5'd4, 32'h0000_0002,32'h0,          32'h0000_0002,32'hFFFF_FFFE,1'b1,4'd10}, // R10
        {3'd7,2'd2,2'd1,5'd7, 32'h0000_7000,32'h0,          32'h0000_7000,32'h0000_7000,1'b0,4'd11}, // R11
        {3'd4,2'd3,2'd3,5'd5, 32'h0000_0080,32'h0000_0100,  32'h0000_0078,32'h0000_0078,1'b1,4'd4},  // R4 src 3
        {3'd5,2'd0,2'd2,5'd0, 32'h0000_0010,32'hFFFF_FFF0,  32'h0000_0010,32'h0000_0000,1'b1,4'd10}, // R10 reg
        {3'd1,2'd3,2'd2,5'd0, 32'h0000_0000,32'h2000_0000,  32'h0000_0000,32'h0000_0000,1'b0,4'd3}   // R3 shift wrap
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] m, input logic [1:0] sz, input logic [1:0] s,
                         input logic [4:0] c, input logic [31:0] b, input logic [31:0] r);
        @(negedge clk);
        req_valid = 1'b1; mode = m; acc_size = sz; disp_src = s;
        disp_const = c; base_ptr = b; disp_reg = r;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #1ms;
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; mode = '0; acc_size = '0; disp_src = '0;
        disp_const = '0; disp_reg = '0; base_ptr = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 acc_valid", {31'b0, acc_valid}, 32'd0);
        check("R1 ptr_wb",    {31'b0, ptr_wb},    32'd0);
        check("R1 eff_addr",  eff_addr, 32'd0);
        check("R1 ptr_new",   ptr_new,  32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [144:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            issue(v[144:142], v[141:140], v[139:138], v[137:133], v[132:101], v[100:69]);
            check({tag, " acc_valid R2"}, {31'b0, acc_valid}, 32'd1);
            check({tag, " eff_addr"}, eff_addr, v[68:37]);
            check({tag, " ptr_new"},  ptr_new,  v[36:5]);
            check({tag, " ptr_wb"},   {31'b0, ptr_wb}, {31'b0, v[4]});
        end

        // R12 idle cycle after a modifying request: strobe drops, values hold
        issue(3'd5, 2'd2, 2'd1, 5'd2, 32'h0000_3000, 32'h0);
        @(negedge clk);
        check("R12 acc_valid idle", {31'b0, acc_valid}, 32'd0);
        check("R12 ptr_wb idle",    {31'b0, ptr_wb},    32'd0);
        check("R12 eff_addr hold",  eff_addr, 32'h0000_3000);
        check("R12 ptr_new hold",   ptr_new,  32'h0000_3008);

        // R2 back-to-back requests, each visible one edge later
        @(negedge clk);
        req_valid = 1'b1; mode = 3'd3; acc_size = 2'd1; disp_src = 2'd1;
        disp_const = 5'd1; base_ptr = 32'h0000_0040; disp_reg = '0;
        @(negedge clk);
        check("R2 first addr", eff_addr, 32'h0000_0042);
        mode = 3'd2; acc_size = 2'd2; disp_const = 5'd4; base_ptr = 32'h0000_0100;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 second addr", eff_addr, 32'h0000_00F0);
        check("R2 second wb",   {31'b0, ptr_wb}, 32'd0);

        // R1 reset clears outputs after activity
        rst = 1'b1;
        @(negedge clk);
        check("R1 eff_addr after reset", eff_addr, 32'd0);
        rst = 1'b0;

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule